// File: doc/BRIEF.md
# MAC Transmit/Receive Command Register

This block is a write/read command word that starts, stops and resets the transmit and receive engines of an Ethernet MAC. It also runs a chip-level soft reset and can raise an interrupt on request from software. Software writes command bits, and the block turns them into engine state, flush pulses and a reset sequence. Reading the word returns the live activity of each engine and whether a soft reset is still running.

Each engine reports two things: whether a packet is in progress, and a pulse when that packet finishes. A disable does not cut the engine off in the middle of a packet. It waits until the packet ends. An engine reset is different: it drops the engine at once and sends a one-cycle flush pulse to its FIFOs. A soft reset flushes both engines and holds them idle for a fixed minimum time. It ends only once the rest of the chip also reports that its reset has finished.

Command bit positions: 0 TX enable, 1 TX disable, 2 RX enable, 3 RX disable, 4 TX reset, 5 RX reset, 7 software interrupt, 8 soft reset. Bit 6 and bits 31:9 have no function.

Top module: `mac_cmd_ctrl`

## Requirements
- R1: After synchronous reset, both active flags, both flush outputs, `soft_rst_o`, `irq_o` and `rd_data_o` are 0.
- R2: A write with bit 0 (TX) or bit 2 (RX) set starts an idle engine. The matching active flag reads 1 from the next cycle. An enable written to an engine that is already active or draining changes nothing and produces no flush.
- R3: A write with bit 1 (TX) or bit 3 (RX) set makes an engine with no packet in progress idle on the next cycle. If a packet is in progress, the engine stays active until the cycle after its packet-done pulse.
- R4: If a disable bit and the enable bit of the same engine are written together, the disable wins. An idle engine stays idle, and an active engine is stopped as in R3.
- R5: A write with bit 4 (TX) or bit 5 (RX) set makes that engine idle on the next cycle, even in the middle of a packet. The same write gives exactly one cycle of the engine's flush output, on the cycle after the write.
- R6: A write with bit 8 set while no soft reset is running does three things on the next cycle: it pulses both flush outputs once, makes both engines idle, and raises `soft_rst_o`. While `soft_rst_o` is 1, all writes are ignored, so the engines stay idle.
- R7: `soft_rst_o` stays high for exactly RST_CYCLES cycles if `rst_done` is already high. Otherwise it stays high until the cycle after `rst_done` is first seen high.
- R8: A write with bit 7 set produces a one-cycle `irq_o` pulse on the next cycle if `irq_mask` is 1, and no pulse if it is 0.
- R9: `rd_data_o` shows the TX active flag in bit 0, the RX active flag in bit 2 and the soft-reset-running flag in bit 8. Every other bit reads 0, including all the disable, reset and interrupt bits.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | DATA_W | Command word |
| rd_data_o | output | DATA_W | Readback word |
| irq_mask | input | 1 | Interrupt enable for the software interrupt |
| irq_o | output | 1 | Interrupt request pulse |
| tx_busy | input | 1 | TX packet in progress |
| tx_done | input | 1 | TX packet finished pulse |
| rx_busy | input | 1 | RX packet in progress |
| rx_done | input | 1 | RX packet finished pulse |
| rst_done | input | 1 | Chip reset complete indication |
| tx_active_o | output | 1 | TX engine active |
| rx_active_o | output | 1 | RX engine active |
| tx_flush_o | output | 1 | TX abort/flush pulse |
| rx_flush_o | output | 1 | RX abort/flush pulse |
| soft_rst_o | output | 1 | Soft reset sequence running |

## Verification
The assertions check these on every cycle:
- a flush pulse always comes with an idle engine;
- a soft reset always keeps both engines idle;
- the unused readback bits stay 0;
- a disable with no packet in progress stops the engine;
- a disable during a packet leaves the engine running;
- a masked software interrupt never raises a request.

Some behaviour can only be shown by the bench's scenarios. One is the full set of command bit combinations applied to each start state. Others are how long a drain lasts, the exact length of the soft reset (and how it stretches when the reset-complete input is late), and enables being ignored during a drain or while a reset is running.

// File: rtl/mac_cmd_pkg.sv
package mac_cmd_pkg;

  // Command word bit positions (software-visible layout)
  localparam int CB_TX_EN  = 0;
  localparam int CB_TX_DIS = 1;
  localparam int CB_RX_EN  = 2;
  localparam int CB_RX_DIS = 3;
  localparam int CB_TX_RST = 4;
  localparam int CB_RX_RST = 5;
  localparam int CB_SWI    = 7;
  localparam int CB_SRST   = 8;

  localparam int ENG_N = 2;   // engine 0 = TX, engine 1 = RX

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_RUN   = 2'd1,
    ENG_DRAIN = 2'd2
  } eng_state_t;

  function automatic int en_pos(input int e);
    return (e == 0) ? CB_TX_EN : CB_RX_EN;
  endfunction

  function automatic int dis_pos(input int e);
    return (e == 0) ? CB_TX_DIS : CB_RX_DIS;
  endfunction

  function automatic int rst_pos(input int e);
    return (e == 0) ? CB_TX_RST : CB_RX_RST;
  endfunction

endpackage

// File: rtl/mac_eng_ctl.sv
module mac_eng_ctl
  import mac_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic force_idle,
  input  logic flush_req,
  input  logic cmd_en,
  input  logic cmd_dis,
  input  logic pkt_busy,
  input  logic pkt_done,
  output logic active_o,
  output logic flush_o
);

  eng_state_t state;
  logic       pkt_open;

  // A packet still holds the engine if it is running and not finishing now
  assign pkt_open = pkt_busy && !pkt_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      flush_o <= 1'b0;
    end else begin
      flush_o <= flush_req;
      if (force_idle || flush_req) begin
        state <= ENG_IDLE;
      end else if (cmd_dis) begin
        // disable has precedence over a simultaneous enable
        state <= (state != ENG_IDLE && pkt_open) ? ENG_DRAIN : ENG_IDLE;
      end else begin
        case (state)
          ENG_IDLE:  if (cmd_en) state <= ENG_RUN;
          ENG_DRAIN: if (!pkt_open) state <= ENG_IDLE;
          default:   state <= state;
        endcase
      end
    end
  end

  assign active_o = (state != ENG_IDLE);

endmodule

// File: rtl/mac_srst_seq.sv
module mac_srst_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done_in,
  output logic busy_o
);

  localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt    <= '0;
      seen   <= 1'b0;
    end else if (start && !busy_o) begin
      busy_o <= 1'b1;
      cnt    <= '0;
      seen   <= done_in;
    end else if (busy_o) begin
      seen <= seen | done_in;
      if (cnt == LAST) begin
        if (seen || done_in) busy_o <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mac_cmd_ctrl.sv
module mac_cmd_ctrl
  import mac_cmd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              irq_mask,
  output logic              irq_o,
  input  logic              tx_busy,
  input  logic              tx_done,
  input  logic              rx_busy,
  input  logic              rx_done,
  input  logic              rst_done,
  output logic              tx_active_o,
  output logic              rx_active_o,
  output logic              tx_flush_o,
  output logic              rx_flush_o,
  output logic              soft_rst_o
);

  logic             srst_busy;
  logic             wr_ok;
  logic             srst_kick;
  logic [ENG_N-1:0] eng_busy;
  logic [ENG_N-1:0] eng_done;
  logic [ENG_N-1:0] eng_act;
  logic [ENG_N-1:0] eng_flush;
  logic             unused_bits;

  assign unused_bits = ^{wr_data[DATA_W-1:CB_SRST+1], wr_data[6]};

  // Writes landing while a soft reset runs are dropped
  assign wr_ok     = wr_en && !srst_busy;
  assign srst_kick = wr_ok && wr_data[CB_SRST];

  assign eng_busy = {rx_busy, tx_busy};
  assign eng_done = {rx_done, tx_done};

  mac_srst_seq #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk     (clk),
    .rst     (rst),
    .start   (srst_kick),
    .done_in (rst_done),
    .busy_o  (srst_busy)
  );

  for (genvar g = 0; g < ENG_N; g++) begin : g_eng
    mac_eng_ctl u_eng (
      .clk        (clk),
      .rst        (rst),
      .force_idle (srst_busy),
      .flush_req  (srst_kick || (wr_ok && wr_data[rst_pos(g)])),
      .cmd_en     (wr_ok && wr_data[en_pos(g)]),
      .cmd_dis    (wr_ok && wr_data[dis_pos(g)]),
      .pkt_busy   (eng_busy[g]),
      .pkt_done   (eng_done[g]),
      .active_o   (eng_act[g]),
      .flush_o    (eng_flush[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= wr_ok && wr_data[CB_SWI] && irq_mask;
  end

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[CB_TX_EN] = eng_act[0];
    rd_data_o[CB_RX_EN] = eng_act[1];
    rd_data_o[CB_SRST]  = srst_busy;
  end

  assign tx_active_o = eng_act[0];
  assign rx_active_o = eng_act[1];
  assign tx_flush_o  = eng_flush[0];
  assign rx_flush_o  = eng_flush[1];
  assign soft_rst_o  = srst_busy;

endmodule

// File: rtl/mac_cmd_ctrl_chk.sv
module mac_cmd_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_mask,
  input logic              irq_o,
  input logic              tx_busy,
  input logic              tx_done,
  input logic              tx_active_o,
  input logic              rx_active_o,
  input logic              tx_flush_o,
  input logic              rx_flush_o,
  input logic              soft_rst_o
);

  // R6: soft reset write flushes both engines and starts the sequence
  a_r6_srst_start: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[8] && !soft_rst_o) |=>
      (soft_rst_o && tx_flush_o && rx_flush_o && !tx_active_o && !rx_active_o));

  // R6: engines held idle while soft reset runs
  a_r6_idle_in_srst: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> (!tx_active_o && !rx_active_o));

  // R5: a flush pulse always coincides with an idle engine
  a_r5_tx_flush_idle: assert property (@(posedge clk) disable iff (rst)
    tx_flush_o |-> !tx_active_o);
  a_r5_rx_flush_idle: assert property (@(posedge clk) disable iff (rst)
    rx_flush_o |-> !rx_active_o);

  // R9: unused and write-only readback bits are zero
  a_r9_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o[DATA_W-1:9] == '0) && (rd_data_o[7:3] == '0) && !rd_data_o[1]);

  // R3/R4: disable with no packet in flight stops TX next cycle
  a_r3_dis_idle_now: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst_o && wr_data[1] && !tx_busy) |=> !tx_active_o);

  // R3: disable during a packet keeps TX running
  a_r3_dis_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst_o && wr_data[1] && !wr_data[4] && !wr_data[8] &&
     tx_active_o && tx_busy && !tx_done) |=> tx_active_o);

  // R8: masked software interrupt raises nothing
  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[7] && !irq_mask) |=> !irq_o);

endmodule

bind mac_cmd_ctrl mac_cmd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data_o   (rd_data_o),
  .irq_mask    (irq_mask),
  .irq_o       (irq_o),
  .tx_busy     (tx_busy),
  .tx_done     (tx_done),
  .tx_active_o (tx_active_o),
  .rx_active_o (rx_active_o),
  .tx_flush_o  (tx_flush_o),
  .rx_flush_o  (rx_flush_o),
  .soft_rst_o  (soft_rst_o)
);

// File: tb/mac_cmd_ctrl_bench.sv
module mac_cmd_ctrl_bench;

  localparam int DW   = 32;
  localparam int RSTC = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data_o;
  logic          irq_mask = 1'b0;
  logic          irq_o;
  logic          tx_busy = 1'b0, tx_done = 1'b0;
  logic          rx_busy = 1'b0, rx_done = 1'b0;
  logic          rst_done = 1'b1;
  logic          tx_active_o, rx_active_o, tx_flush_o, rx_flush_o, soft_rst_o;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  mac_cmd_ctrl #(.DATA_W(DW), .RST_CYCLES(RSTC)) u_mac_cmd_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data_o(rd_data_o), .irq_mask(irq_mask), .irq_o(irq_o),
    .tx_busy(tx_busy), .tx_done(tx_done), .rx_busy(rx_busy), .rx_done(rx_done),
    .rst_done(rst_done), .tx_active_o(tx_active_o), .rx_active_o(rx_active_o),
    .tx_flush_o(tx_flush_o), .rx_flush_o(rx_flush_o), .soft_rst_o(soft_rst_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, return at the next negedge (results of that edge visible)
  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit nxt(input bit a, input bit en, input bit dis, input bit r);
    if (r || dis) return 1'b0;
    if (en) return 1'b1;
    return a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_active", tx_active_o, 0);
    chk("R1 rx_active", rx_active_o, 0);
    chk("R1 flushes", {tx_flush_o, rx_flush_o}, 0);
    chk("R1 soft_rst/irq", {soft_rst_o, irq_o}, 0);
    chk("R1 rd_data", rd_data_o, 0);

    // Sweep: every TX/RX start state against every combination of bits 5:0
    for (int st = 0; st < 4; st++) begin
      for (int c = 0; c < 64; c++) begin
        bit st_t, st_r, et, er;
        st_t = st[0]; st_r = st[1];
        wr(32'h30);
        wr({29'd0, st_r, 1'b0, st_t});
        wr(c);
        et = nxt(st_t, c[0], c[1], c[4]);
        er = nxt(st_r, c[2], c[3], c[5]);
        // R2 R3 R4 R5 via arithmetic model
        chk($sformatf("R2/R3/R4 tx st=%0d c=%0h", st, c), tx_active_o, et);
        chk($sformatf("R2/R3/R4 rx st=%0d c=%0h", st, c), rx_active_o, er);
        chk($sformatf("R5 flush st=%0d c=%0h", st, c), {rx_flush_o, tx_flush_o}, {c[5], c[4]});
        chk($sformatf("R9 readback st=%0d c=%0h", st, c), rd_data_o, {29'd0, er, 1'b0, et});
        @(negedge clk);
        chk($sformatf("R5 flush one cycle c=%0h", c), {rx_flush_o, tx_flush_o}, 0);
      end
    end

    // R3 drain: TX disable with packet in flight
    wr(32'h30);
    wr(32'h01);
    tx_busy = 1'b1;
    wr(32'h02);
    chk("R3 tx held during packet", tx_active_o, 1);
    wr(32'h01);  // R2 enable during drain ignored
    chk("R2 enable in drain no flush", tx_flush_o, 0);
    idle(3);
    chk("R3 tx still draining", tx_active_o, 1);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; tx_busy = 1'b0;
    chk("R3 tx idle after done", tx_active_o, 0);
    idle(2);
    chk("R2 enable in drain stayed ignored", tx_active_o, 0);

    // R4 disable+enable on active RX with packet in flight
    wr(32'h04);
    rx_busy = 1'b1;
    wr(32'h0C);
    chk("R4 rx drains", rx_active_o, 1);
    rx_done = 1'b1;
    @(negedge clk);
    rx_done = 1'b0; rx_busy = 1'b0;
    chk("R4 rx idle", rx_active_o, 0);

    // R5 reset aborts mid-packet
    wr(32'h05);
    tx_busy = 1'b1; rx_busy = 1'b1;
    wr(32'h30);
    chk("R5 abort mid-packet", {rx_active_o, tx_active_o}, 0);
    chk("R5 flush mid-packet", {rx_flush_o, tx_flush_o}, 2'b11);
    tx_busy = 1'b0; rx_busy = 1'b0;

    // R6/R7 soft reset with rst_done already high
    wr(32'h05);
    rst_done = 1'b1;
    wr(32'h100);
    chk("R6 flushes", {rx_flush_o, tx_flush_o}, 2'b11);
    chk("R6 engines idle", {rx_active_o, tx_active_o}, 0);
    chk("R9 bit8 running", rd_data_o, 32'h100);
    begin
      int n = 0;
      while (soft_rst_o && n < 100) begin
        n++;
        @(negedge clk);
        if (n == 1) chk("R6 flush single cycle", {rx_flush_o, tx_flush_o}, 0);
      end
      chk("R7 length", n, RSTC);
    end

    // R7 late rst_done, R6 writes ignored
    rst_done = 1'b0;
    wr(32'h100);
    wr(32'h85);
    irq_mask = 1'b1;
    chk("R6 enable ignored", {rx_active_o, tx_active_o}, 0);
    chk("R6 swi ignored", irq_o, 0);
    idle(30);
    chk("R7 extended", soft_rst_o, 1);
    rst_done = 1'b1;
    @(negedge clk);
    chk("R7 ends after rst_done", soft_rst_o, 0);
    chk("R7 engines still idle", {rx_active_o, tx_active_o}, 0);

    // R8 software interrupt
    irq_mask = 1'b1;
    wr(32'h80);
    chk("R8 irq pulse", irq_o, 1);
    @(negedge clk);
    chk("R8 irq one cycle", irq_o, 0);
    irq_mask = 1'b0;
    wr(32'h80);
    chk("R8 masked", irq_o, 0);

    // R9 all-ones write readback
    wr(32'hFFFF_FFFF);
    chk("R9 all-ones readback", rd_data_o, 32'h100);
    idle(RSTC + 2);
    chk("R9 back to zero", rd_data_o, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule